// File: doc/BRIEF.md
# Dual-Channel Event-Action PWM Generator

The block produces two pulse-width-modulated outputs from one shared timebase counter. A prescaler divides the system clock by 2, 4, 8 or 16 and yields a one-cycle advance strobe. On each strobe the counter either counts down and reloads the top value after zero, or runs up and down between zero and top so that the output edges are centre-aligned. The counter value is compared with zero, with top, and with two compare values A and B. The compare matches are qualified by the direction in which the counter arrived, which gives six events.

Each output channel holds a 12-bit action word. The word gives every event a 2-bit code: leave the output as it is, set it, clear it or toggle it. When several events coincide, one fixed priority picks the code that applies. A global run input, a per-channel enable and a per-channel output inversion complete the configuration. All settings arrive on plain input ports, and no register interface is part of the block.

Top module: `pwm_dual_event`

## Requirements
- R1: With `div_sel` one-hot, bit k set (k = 0..3), the counter advances once every 2^(k+1) clock cycles. The prescaler counts from 0 after reset or run, and the first advance comes when it has counted 2^(k+1)-1 cycles.
- R2: A `div_sel` value that is not one-hot (including 0000) divides by 2.
- R3: With `updown` = 0 the counter steps down by one on each advance and loads `cnt_top` on the advance after it reaches 0. Only events e0, e3, e4 and e5 can fire in this mode.
- R4: With `updown` = 1 the counter rises to `cnt_top`, then falls to 0, then rises again. The advance that leaves top goes to top-1, and the advance that leaves 0 goes to 1. When top is 0 the counter stays at 0. All six events can fire.
- R5: Events are evaluated on the value the counter has just taken, and on the direction in which it arrived. e0 fires when the count is 0. e1 fires when the count equals A while rising. e2 fires when it equals B while rising. e3 fires when it equals top. e4 fires when it equals B while falling. e5 fires when it equals A while falling. The code for event ei sits in bits [2i+1:2i] of `act_a` and of `act_b`.
- R6: The action codes are 00 leave unchanged, 01 set to 1, 10 clear to 0, and 11 invert the current level.
- R7: When several events fire on one advance, the highest-numbered firing event whose code is not 00 decides the action. Toggle inverts the level held before that advance.
- R8: While a channel's enable is low, that channel's level is 0 and its pin equals its inversion flag.
- R9: Each pin is its channel level XOR its inversion flag. The pin follows an inversion change combinationally.
- R10: While `run` is low, the prescaler and the counter are held at 0, the direction is falling, and both channel levels are 0. After `run` rises the block restarts exactly as it does after reset.
- R11: Reset is synchronous and active high. It clears the counter, the prescaler and both levels.
- R12: A channel level changes only at the clock edge that follows the edge at which the counter took a new value, or when its enable or `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Global enable for prescaler, counter and channels |
| updown | input | 1 | 1: up/down counting, 0: down-only counting |
| div_sel | input | 4 | One-hot prescaler select (/2, /4, /8, /16) |
| cnt_top | input | 32 | Counter top value |
| cmp_a | input | 32 | Compare value A |
| cmp_b | input | 32 | Compare value B |
| ch_en_a | input | 1 | Channel A enable |
| ch_en_b | input | 1 | Channel B enable |
| inv_a | input | 1 | Channel A output inversion |
| inv_b | input | 1 | Channel B output inversion |
| act_a | input | 12 | Channel A action codes, six 2-bit fields |
| act_b | input | 12 | Channel B action codes, six 2-bit fields |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
An advance strobe is raised combinationally in the cycle in which the prescaler reaches its limit. The counter takes its new value at that clock edge, and a channel level changes one edge later. An inversion change reaches the pin in the same cycle, while a change of enable or run clears the level at the next edge. The bench keeps a cycle model with exactly these delays and updates it on every rising edge. Inputs are driven only after a falling edge, and both pins are compared with the model at every falling edge, so each result is read in the cycle in which it is due. Across the sweeps the bench covers both counting modes, every divider select including illegal ones, coinciding events, and the settings top = 0 and compare = top.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DIV_SEL_W = 4;
    localparam int EVT_N     = 6;
    localparam int ACT_W     = 2;
    localparam int ACT_WORD_W = EVT_N * ACT_W;

    // event indices; order is also the priority (higher index wins)
    localparam int EV_ZERO   = 0;
    localparam int EV_A_UP   = 1;
    localparam int EV_B_UP   = 2;
    localparam int EV_TOP    = 3;
    localparam int EV_B_DOWN = 4;
    localparam int EV_A_DOWN = 5;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_SET    = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef logic [EVT_N-1:0] evt_vec_t;

    // prescaler wrap value: 2^(k+1)-1 for one-hot bit k, else 1 (divide by 2)
    function automatic logic [DIV_SEL_W-1:0] div_limit(input logic [DIV_SEL_W-1:0] sel);
        int ones;
        int idx;
        int lim;
        ones = 0;
        idx  = 0;
        for (int i = 0; i < DIV_SEL_W; i++) begin
            if (sel[i]) begin
                ones++;
                idx = i;
            end
        end
        lim = (ones == 1) ? ((1 << (idx + 1)) - 1) : 1;
        return DIV_SEL_W'(lim);
    endfunction

    // highest-numbered firing event with a non-idle code decides
    function automatic act_e pick_action(input evt_vec_t hit,
                                         input logic [ACT_WORD_W-1:0] word);
        act_e sel;
        sel = ACT_NONE;
        for (int i = 0; i < EVT_N; i++) begin
            if (hit[i] && (word[i*ACT_W +: ACT_W] != ACT_NONE))
                sel = act_e'(word[i*ACT_W +: ACT_W]);
        end
        return sel;
    endfunction

    function automatic logic apply_action(input act_e a, input logic cur);
        case (a)
            ACT_SET:    return 1'b1;
            ACT_CLEAR:  return 1'b0;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);

    logic [DIV_SEL_W-1:0] pre_q;
    logic [DIV_SEL_W-1:0] limit;

    assign limit = div_limit(div_sel);
    assign tick  = run && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + DIV_SEL_W'(1);
    end

    // R1: division is at least 2, so strobes never come back to back
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             updown,
    input  logic [CNT_W-1:0] cnt_top,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output evt_vec_t         evt,
    output logic             upd
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             rising_q;
    logic             upd_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q    <= '0;
            rising_q <= 1'b0;
            upd_q    <= 1'b0;
        end else begin
            upd_q <= tick;
            if (tick) begin
                if (!updown) begin
                    rising_q <= 1'b0;
                    cnt_q    <= (cnt_q == '0) ? cnt_top : cnt_q - ONE;
                end else if (rising_q) begin
                    if (cnt_q >= cnt_top) begin
                        rising_q <= 1'b0;
                        cnt_q    <= (cnt_q == '0) ? '0 : cnt_q - ONE;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        rising_q <= 1'b1;
                        cnt_q    <= (cnt_top == '0) ? '0 : ONE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
            end
        end
    end

    // event decode on the freshly taken value and its arrival direction
    always_comb begin
        evt            = '0;
        evt[EV_ZERO]   = (cnt_q == '0);
        evt[EV_A_UP]   = rising_q  && (cnt_q == cmp_a);
        evt[EV_B_UP]   = rising_q  && (cnt_q == cmp_b);
        evt[EV_TOP]    = (cnt_q == cnt_top);
        evt[EV_B_DOWN] = !rising_q && (cnt_q == cmp_b);
        evt[EV_A_DOWN] = !rising_q && (cnt_q == cmp_a);
        if (!upd_q)
            evt = '0;
    end

    assign upd = upd_q;

    // R3: an update made in down-only mode leaves the direction falling
    p_down_only_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !updown) |=> !rising_q);

    // R4: each update moves by one, reloads top, or stays at zero
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE) ||
                   (cnt_q == $past(cnt_top)) || (cnt_q == '0)));

    // R10: a low run forces the counter to zero
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0) && !upd_q);

    // R3: rising-only events stay silent in down-only mode
    p_no_up_evt_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_q && $past(!updown)) |-> !evt[EV_A_UP] && !evt[EV_B_UP]);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  ch_en,
    input  logic                  inv,
    input  logic [ACT_WORD_W-1:0] act_word,
    input  evt_vec_t              evt,
    input  logic                  upd,
    output logic                  pin
);

    logic level_q;
    act_e chosen;

    assign chosen = pick_action(evt, act_word);

    always_ff @(posedge clk) begin
        if (rst || !run || !ch_en)
            level_q <= 1'b0;
        else if (upd)
            level_q <= apply_action(chosen, level_q);
    end

    assign pin = level_q ^ inv;

    // R8: a disabled channel settles at level zero
    p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!ch_en || !run) |=> (pin == inv));

    // R12: without an update the level holds
    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!upd && run && ch_en) |=> $stable(level_q));

endmodule

// File: rtl/pwm_dual_event.sv
module pwm_dual_event
    import pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  updown,
    input  logic [DIV_SEL_W-1:0]  div_sel,
    input  logic [CNT_W-1:0]      cnt_top,
    input  logic [CNT_W-1:0]      cmp_a,
    input  logic [CNT_W-1:0]      cmp_b,
    input  logic                  ch_en_a,
    input  logic                  ch_en_b,
    input  logic                  inv_a,
    input  logic                  inv_b,
    input  logic [ACT_WORD_W-1:0] act_a,
    input  logic [ACT_WORD_W-1:0] act_b,
    output logic                  pwm_a,
    output logic                  pwm_b
);

    localparam int CH_N = 2;

    logic                  tick;
    logic                  upd;
    evt_vec_t              evt;
    logic [CH_N-1:0]       en_v;
    logic [CH_N-1:0]       inv_v;
    logic [CH_N-1:0]       pin_v;
    logic [ACT_WORD_W-1:0] act_v [CH_N];

    assign en_v     = {ch_en_b, ch_en_a};
    assign inv_v    = {inv_b, inv_a};
    assign act_v[0] = act_a;
    assign act_v[1] = act_b;

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_sel (div_sel),
        .tick    (tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (tick),
        .updown  (updown),
        .cnt_top (cnt_top),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .evt     (evt),
        .upd     (upd)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        pwm_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (run),
            .ch_en    (en_v[c]),
            .inv      (inv_v[c]),
            .act_word (act_v[c]),
            .evt      (evt),
            .upd      (upd),
            .pin      (pin_v[c])
        );
    end

    assign pwm_a = pin_v[0];
    assign pwm_b = pin_v[1];

    // R11: one clock after reset both pins show only the inversion flags
    p_reset_r11: assert property (@(posedge clk)
        rst |=> (pwm_a == $past(inv_a)) && (pwm_b == $past(inv_b)));

endmodule

// File: tb/test_pwm_dual_event.sv
module test_pwm_dual_event;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        updown = 1'b0;
    logic [3:0]  div_sel = 4'b0001;
    logic [W-1:0] cnt_top = '0, cmp_a = '0, cmp_b = '0;
    logic        ch_en_a = 1'b1, ch_en_b = 1'b1, inv_a = 1'b0, inv_b = 1'b0;
    logic [11:0] act_a = '0, act_b = '0;
    logic        pwm_a, pwm_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    pwm_dual_event #(.CNT_W(W)) i_pwm_dual_event (
        .clk(clk), .rst(rst), .run(run), .updown(updown), .div_sel(div_sel),
        .cnt_top(cnt_top), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .ch_en_a(ch_en_a), .ch_en_b(ch_en_b), .inv_a(inv_a), .inv_b(inv_b),
        .act_a(act_a), .act_b(act_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // cycle model built from the requirements
    int       m_pre = 0;
    logic [W-1:0] m_cnt = '0;
    bit       m_rise = 0, m_upd = 0, m_la = 0, m_lb = 0;

    function automatic int ratio(input logic [3:0] s);
        case (s)
            4'b0001: return 2;
            4'b0010: return 4;
            4'b0100: return 8;
            4'b1000: return 16;
            default: return 2;
        endcase
    endfunction

    function automatic bit next_level(input bit cur, input logic [11:0] w,
                                      input logic [5:0] e);
        logic [1:0] code;
        code = 2'b00;
        for (int i = 0; i < 6; i++)
            if (e[i] && w[2*i +: 2] != 2'b00) code = w[2*i +: 2];
        case (code)
            2'b01: return 1'b1;
            2'b10: return 1'b0;
            2'b11: return ~cur;
            default: return cur;
        endcase
    endfunction

    always @(posedge clk) begin
        int p_n; logic [W-1:0] c_n; bit r_n, u_n, a_n, b_n, tk;
        logic [5:0] e;
        e = '0;
        if (m_upd) begin
            e[0] = (m_cnt == 0);
            e[1] = m_rise && (m_cnt == cmp_a);
            e[2] = m_rise && (m_cnt == cmp_b);
            e[3] = (m_cnt == cnt_top);
            e[4] = !m_rise && (m_cnt == cmp_b);
            e[5] = !m_rise && (m_cnt == cmp_a);
        end
        tk = run && (m_pre >= ratio(div_sel) - 1);
        p_n = tk ? 0 : m_pre + 1;
        c_n = m_cnt; r_n = m_rise;
        if (tk) begin
            if (!updown) begin
                r_n = 0; c_n = (m_cnt == 0) ? cnt_top : m_cnt - 1;
            end else if (m_rise) begin
                if (m_cnt >= cnt_top) begin r_n = 0; c_n = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else c_n = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin r_n = 1; c_n = (cnt_top == 0) ? 0 : 1; end
                else c_n = m_cnt - 1;
            end
        end
        u_n = tk;
        a_n = m_upd ? next_level(m_la, act_a, e) : m_la;
        b_n = m_upd ? next_level(m_lb, act_b, e) : m_lb;
        if (rst || !run) begin p_n = 0; c_n = 0; r_n = 0; u_n = 0; end
        if (rst || !run || !ch_en_a) a_n = 0;
        if (rst || !run || !ch_en_b) b_n = 0;
        m_pre = p_n; m_cnt = c_n; m_rise = r_n; m_upd = u_n; m_la = a_n; m_lb = b_n;
    end

    task automatic step(input string tag);
        bit ea, eb;
        @(negedge clk);
        ea = m_la ^ inv_a;
        eb = m_lb ^ inv_b;
        n_cmp += 2;
        if (pwm_a !== ea) begin
            n_bad++;
            $display("FAIL %s pwm_a actual=%b expected=%b at %0t", tag, pwm_a, ea, $time);
        end
        if (pwm_b !== eb) begin
            n_bad++;
            $display("FAIL %s pwm_b actual=%b expected=%b at %0t", tag, pwm_b, eb, $time);
        end
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        step(tag);
        rst = 1'b0;
    endtask

    initial begin
        logic [3:0] divs [6];
        logic [W-1:0] tops [4], cas [4], cbs [4];
        logic [11:0] aa [2], ab [2];
        string tag;
        divs[0] = 4'b0001; divs[1] = 4'b0010; divs[2] = 4'b0100;
        divs[3] = 4'b1000; divs[4] = 4'b0000; divs[5] = 4'b0110;
        tops[0] = 5; cas[0] = 2; cbs[0] = 4;
        tops[1] = 6; cas[1] = 0; cbs[1] = 6;
        tops[2] = 3; cas[2] = 3; cbs[2] = 3;
        tops[3] = 0; cas[3] = 0; cbs[3] = 1;
        aa[0] = {2'b10, 2'b01, 2'b11, 2'b10, 2'b01, 2'b01};
        ab[0] = {2'b00, 2'b11, 2'b10, 2'b01, 2'b11, 2'b01};
        aa[1] = 12'hFFF;
        ab[1] = {2'b01, 2'b00, 2'b10, 2'b00, 2'b00, 2'b11};

        // R11: reset state
        run = 1'b1;
        do_reset("R11");
        steps(3, "R11");

        // sweep: modes x divider selects x shapes x action words
        for (int md = 0; md < 2; md++)
            for (int d = 0; d < 6; d++)
                for (int s = 0; s < 4; s++)
                    for (int k = 0; k < 2; k++) begin
                        @(negedge clk);
                        updown = md[0]; div_sel = divs[d];
                        cnt_top = tops[s]; cmp_a = cas[s]; cmp_b = cbs[s];
                        act_a = aa[k]; act_b = ab[k];
                        inv_a = s[0]; inv_b = k[0];
                        tag = $sformatf("%s %s R5 R6 R7 R12",
                                        (d < 4) ? "R1" : "R2", md ? "R4" : "R3");
                        do_reset("R11");
                        steps(160 + 40 * d, tag);
                    end

        // channel enables
        @(negedge clk);
        updown = 1'b1; div_sel = 4'b0001; cnt_top = 5; cmp_a = 2; cmp_b = 4;
        act_a = aa[0]; act_b = ab[0]; inv_a = 1'b1; inv_b = 1'b0;
        do_reset("R11");
        steps(30, "R4");
        ch_en_a = 1'b0;
        steps(40, "R8");
        ch_en_a = 1'b1; ch_en_b = 1'b0;
        steps(40, "R8");
        ch_en_b = 1'b1;
        steps(30, "R8 R12");

        // inversion flips between edges
        for (int i = 0; i < 12; i++) begin
            inv_a = ~inv_a;
            if (i % 3 == 0) inv_b = ~inv_b;
            steps(5, "R9");
        end

        // global run low, then restart
        run = 1'b0;
        steps(25, "R10");
        run = 1'b1;
        steps(80, "R10");
        run = 1'b0;
        steps(3, "R10");
        run = 1'b1;
        updown = 1'b0;
        steps(60, "R10 R3");

        // reset in mid-run
        do_reset("R11");
        steps(40, "R11");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule